// File: doc/BRIEF.md
# Prioritized Local Error Reporter

This block sits beside a link controller and turns up to thirty single-cycle error event lines into a serial stream of error reports. Each event line carries its own 5-bit error code. In each clock cycle the block reports at most one code on a registered code bus, together with a one-cycle valid strobe.

Every code has a fixed priority, and that priority is separate from its numeric value. When several events are live in the same cycle, the one with the lowest priority number is reported. Events that lose are not dropped. Each source has a pending bit that holds its event until the event wins a later cycle.

A source that fires again while it is still pending is merged into its existing pending bit. It does not produce an extra report. The block does not detect the errors itself and keeps no error log.

Top module: `lerr_reporter`

## Requirements
- R1: While reset is active and until the first event after reset, `err_vld` is 0, `err_code` is 0 and no source is pending.
- R2: A lone event on `err_evt[i]`, with nothing pending, is reported in the next cycle: `err_vld` is 1 for that one cycle and `err_code` equals i+1.
- R3: Whenever `err_vld` is 1, `err_code` lies in 1 to 30. The codes 0 and 31 are never reported.
- R4: Among all live sources (pending, or pulsing this cycle), the one with the lowest priority number is reported. The fixed mapping, written code:priority, is 24:0, 23:1, 10:2, 12:3, 8:4, 17:5, 13:6, 14:7, 15:8, 16:9, 6:10, 26:12, 28:13, 30:14, 4:15, 5:16, 2:17, 3:18, 19:19, 18:20, 1:21, 20:22, 21:23, 22:24, 9:25, 11:26, 7:27, 25:28, 27:29, 29:30.
- R5: A live source that loses stays pending. It is reported in a later cycle, one report per cycle, in priority order among whatever is live then.
- R6: An event on a source that is already pending merges into it and yields no second report.
- R7: When nothing is pending and no event pulses in a cycle, the next cycle shows `err_vld` 0 and `err_code` 0.
- R8: The outputs are registered. An event or a pending winner in cycle t appears on the outputs in cycle t+1.
- R9: An event on a source in the same cycle that source is chosen as the winner is absorbed into that report. The source does not stay pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| err_evt | input | 30 | Error event pulses; bit i carries code i+1 |
| err_code | output | 5 | Reported error code, 0 when idle |
| err_vld | output | 1 | One-cycle strobe per reported code |

## Verification
The assertions take for granted that event pulses arrive only after the internal reset has been released. With that assumption, any live source must either be reported or remain pending in the next cycle. The bench honours this by holding `err_evt` at zero through reset and for three cycles after release. It then applies single events on every code, pairs and full bursts that exercise the priority order, repeats on pending sources, and hits on the source that is being reported. The rest of the stimulus is sparse random traffic.

// File: rtl/lerr_pkg.sv
package lerr_pkg;
  localparam int NUM_SRC  = 30;
  localparam int CODE_W   = 5;
  localparam int NUM_RANK = 31;
  localparam int RANK_W   = $clog2(NUM_RANK);

  // fixed priority rank of each code; lower rank wins
  function automatic logic [RANK_W-1:0] rank_of_code(input int code);
    case (code)
      1:  return RANK_W'(21);
      2:  return RANK_W'(17);
      3:  return RANK_W'(18);
      4:  return RANK_W'(15);
      5:  return RANK_W'(16);
      6:  return RANK_W'(10);
      7:  return RANK_W'(27);
      8:  return RANK_W'(4);
      9:  return RANK_W'(25);
      10: return RANK_W'(2);
      11: return RANK_W'(26);
      12: return RANK_W'(3);
      13: return RANK_W'(6);
      14: return RANK_W'(7);
      15: return RANK_W'(8);
      16: return RANK_W'(9);
      17: return RANK_W'(5);
      18: return RANK_W'(20);
      19: return RANK_W'(19);
      20: return RANK_W'(22);
      21: return RANK_W'(23);
      22: return RANK_W'(24);
      23: return RANK_W'(1);
      24: return RANK_W'(0);
      25: return RANK_W'(28);
      26: return RANK_W'(12);
      27: return RANK_W'(29);
      28: return RANK_W'(13);
      29: return RANK_W'(30);
      30: return RANK_W'(14);
      default: return RANK_W'(11);
    endcase
  endfunction

  // inverse lookup; ranks with no code return 0
  function automatic int code_of_rank(input int rank);
    int found;
    found = 0;
    for (int c = 1; c <= NUM_SRC; c++)
      if (int'(rank_of_code(c)) == rank) found = c;
    return found;
  endfunction
endpackage

// File: rtl/lerr_rank_map.sv
module lerr_rank_map
  import lerr_pkg::*;
#(
  parameter int N_SRC  = NUM_SRC,
  parameter int N_RANK = NUM_RANK
) (
  input  logic [N_SRC-1:0]  by_src,
  output logic [N_RANK-1:0] by_rank
);
  for (genvar r = 0; r < N_RANK; r++) begin : g_rank
    localparam int SRC_CODE = code_of_rank(r);
    if (SRC_CODE == 0) begin : g_hole
      assign by_rank[r] = 1'b0;
    end else begin : g_src
      assign by_rank[r] = by_src[SRC_CODE-1];
    end
  end
endmodule

// File: rtl/lerr_pick.sv
module lerr_pick
  import lerr_pkg::*;
#(
  parameter int N_RANK = NUM_RANK,
  localparam int IDX_W = $clog2(N_RANK)
) (
  input  logic [N_RANK-1:0] by_rank,
  output logic              hit,
  output logic [IDX_W-1:0]  win_rank
);
  always_comb begin
    hit      = |by_rank;
    win_rank = '0;
    for (int r = N_RANK - 1; r >= 0; r--)
      if (by_rank[r]) win_rank = IDX_W'(r);
  end
endmodule

// File: rtl/lerr_pend.sv
module lerr_pend
  import lerr_pkg::*;
#(
  parameter int N_SRC = NUM_SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt,
  input  logic              win_hit,
  input  logic [RANK_W-1:0] win_rank,
  output logic [N_SRC-1:0]  live,
  output logic [N_SRC-1:0]  pend_q
);
  logic [N_SRC-1:0] clr_src;
  logic [N_SRC-1:0] pend_d;
  logic             pend_en;

  for (genvar s = 0; s < N_SRC; s++) begin : g_clr
    localparam logic [RANK_W-1:0] SRC_RANK = rank_of_code(s + 1);
    assign clr_src[s] = win_hit && (win_rank == SRC_RANK);
  end

  always_comb begin
    live    = pend_q | evt;
    pend_d  = live & ~clr_src;
    pend_en = (|evt) | win_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end
endmodule

// File: rtl/lerr_reporter.sv
module lerr_reporter
  import lerr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] err_evt,
  output logic [CODE_W-1:0]  err_code,
  output logic               err_vld
);
  logic [1:0]          rst_ff;
  logic                rst_sync_n;
  logic [NUM_SRC-1:0]  live;
  logic [NUM_SRC-1:0]  pend_vec;
  logic [NUM_RANK-1:0] live_rank;
  logic                win_hit;
  logic [RANK_W-1:0]   win_rank;
  logic [CODE_W-1:0]   win_code;
  logic                out_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  lerr_pend #(.N_SRC(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt      (err_evt),
    .win_hit  (win_hit),
    .win_rank (win_rank),
    .live     (live),
    .pend_q   (pend_vec)
  );

  lerr_rank_map #(.N_SRC(NUM_SRC), .N_RANK(NUM_RANK)) u_map (
    .by_src  (live),
    .by_rank (live_rank)
  );

  lerr_pick #(.N_RANK(NUM_RANK)) u_pick (
    .by_rank  (live_rank),
    .hit      (win_hit),
    .win_rank (win_rank)
  );

  always_comb begin
    win_code = '0;
    for (int c = 1; c <= NUM_SRC; c++)
      if (win_hit && (win_rank == rank_of_code(c))) win_code = CODE_W'(c);
    out_en = win_hit | err_vld;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_code <= '0;
      err_vld  <= 1'b0;
    end else if (out_en) begin
      err_code <= win_code;
      err_vld  <= win_hit;
    end
  end
endmodule

// File: rtl/lerr_reporter_chk.sv
module lerr_reporter_chk
  import lerr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] err_evt,
  input logic [NUM_SRC-1:0] pend,
  input logic [CODE_W-1:0]  err_code,
  input logic               err_vld
);
  logic               past_ok;
  logic [NUM_SRC-1:0] clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_comb begin
    clr_mask = '0;
    if (err_vld && err_code != 5'd0 && err_code != 5'd31)
      clr_mask = NUM_SRC'(1) << (err_code - 5'd1);
  end

  p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> (err_code != 5'd0 && err_code != 5'd31));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt == '0 && pend == '0) |=> (!err_vld && err_code == 5'd0));

  p_report_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt) |=> err_vld);

  // a pending source stays pending until its own code is reported
  p_pend_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((($past(pend) & ~clr_mask) & ~pend) == '0));

  // every pulse is either reported now or held
  p_no_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((($past(err_evt) & ~clr_mask) & ~pend) == '0));

  // the reported source is not left pending (R9)
  p_clear_on_report_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> ((pend & clr_mask) == '0));

  p_reset_clean_r1: assert property (@(posedge clk)
    !rst_n |-> (!err_vld && pend == '0));
endmodule

bind lerr_reporter lerr_reporter_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .err_evt  (err_evt),
  .pend     (pend_vec),
  .err_code (err_code),
  .err_vld  (err_vld)
);

// File: tb/lerr_reporter_test.sv
module lerr_reporter_test;
  logic        clk;
  logic        rst_n;
  logic [29:0] err_evt;
  logic [4:0]  err_code;
  logic        err_vld;

  int vectors = 0;
  int fails   = 0;

  // behavioural reference state
  bit  ref_pend [1:30];
  int  exp_code;
  bit  exp_vld;
  int  reports;

  lerr_reporter uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .err_evt  (err_evt),
    .err_code (err_code),
    .err_vld  (err_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int prio(input int c);
    case (c)
      24: return 0;  23: return 1;  10: return 2;  12: return 3;
      8:  return 4;  17: return 5;  13: return 6;  14: return 7;
      15: return 8;  16: return 9;  6:  return 10; 26: return 12;
      28: return 13; 30: return 14; 4:  return 15; 5:  return 16;
      2:  return 17; 3:  return 18; 19: return 19; 18: return 20;
      1:  return 21; 20: return 22; 21: return 23; 22: return 24;
      9:  return 25; 11: return 26; 7:  return 27; 25: return 28;
      27: return 29; 29: return 30;
      default: return 99;
    endcase
  endfunction

  // compare current outputs, then apply ev and advance the model
  task automatic step(input logic [29:0] ev, input string tag);
    int best;
    @(negedge clk);
    vectors++;
    if (err_vld !== exp_vld || int'(err_code) != exp_code) begin
      fails++;
      $display("FAIL %s: code=%0d vld=%0b expected code=%0d vld=%0b",
               tag, err_code, err_vld, exp_code, exp_vld);
    end
    if (err_vld === 1'b1) reports++;
    err_evt = ev;
    for (int c = 1; c <= 30; c++) if (ev[c-1]) ref_pend[c] = 1'b1;
    best = 0;
    for (int c = 1; c <= 30; c++)
      if (ref_pend[c] && (best == 0 || prio(c) < prio(best))) best = c;
    exp_vld  = (best != 0);
    exp_code = best;
    if (best != 0) ref_pend[best] = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: code=%0d vld=%0b expected code=%0d vld=%0b",
             err_code, err_vld, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int r0;
    for (int c = 1; c <= 30; c++) ref_pend[c] = 1'b0;
    exp_code = 0;
    exp_vld  = 1'b0;
    reports  = 0;
    err_evt  = '0;
    rst_n    = 1'b0;
    // R1: outputs stay clear while in reset
    for (int k = 0; k < 4; k++) step('0, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) step('0, "R1 after release");

    // R2, R8: each code alone, then idle
    for (int c = 1; c <= 30; c++) begin
      step(30'(1) << (c - 1), "R2 single");
      step('0, "R8 latency");
      step('0, "R7 idle");
    end

    // R4: pairs of codes at once
    step(30'(1) << 23 | 30'(1) << 22, "R4 pair 24/23");
    step('0, "R5 loser");
    step('0, "R7 idle");
    step(30'(1) << 9 | 30'(1) << 12, "R4 pair 10/13");
    step('0, "R5 loser");
    step('0, "R7 idle");
    step(30'(1) << 0 | 30'(1) << 28, "R4 pair 1/29");
    step('0, "R5 loser");
    step('0, "R7 idle");

    // R3, R5: every source at once drains in priority order
    step('1, "R5 burst");
    for (int k = 0; k < 32; k++) step('0, "R3 drain");

    // R6: repeat on a pending low-priority source
    step(30'(1) << 23 | 30'(1) << 28, "R6 seed");
    step(30'(1) << 28, "R6 repeat");
    step(30'(1) << 28, "R6 repeat");
    step('0, "R6 drain");
    step('0, "R6 drain");
    step('0, "R7 idle");

    // R9: a source fires in the very cycle it wins from pending
    step(30'(1) << 23 | 30'(1) << 22, "R9 seed");
    step(30'(1) << 22, "R9 absorb");
    step('0, "R9 no extra");
    step('0, "R7 idle");

    // sparse random traffic
    for (int k = 0; k < 2000; k++) begin
      r0 = $urandom;
      step(30'($urandom & $urandom & $urandom) & {30{r0[0]}}, "R5 random");
    end
    for (int k = 0; k < 35; k++) step('0, "R5 final drain");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule